// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block is the fetch and sequencing front end of a small 8-bit-class processor. It holds a 21-bit byte program counter and requests one 16-bit instruction word per cycle from a synchronous word memory. The memory returns the data one cycle after the address. Because instruction words always start on even byte addresses, the counter's low bit stays zero and the memory is addressed with counter bits [20:1]. Within each word, the less significant byte belongs to the even byte address.

The sequencer classifies each returned word. Four opcode groups take two words. For these, the sequencer waits one cycle for the companion word, captures its 12-bit literal, and hands the execute stage one combined operation. Any word whose top nibble is 1111 that arrives where a first word is expected executes as a no-operation. So a companion word reached on its own, for example after a conditional skip, has no effect. The sequencer also resolves absolute jumps and calls, relative branches and taken skips. The execute stage supplies the skip and branch conditions as inputs, valid in the cycle the deciding word is decoded. Results reach the execute stage through a registered issue port.

Opcode encoding (word bits [15:0]):
- jump, two words: [15:8] = 8'hEF
- call, two words: [15:9] = 7'b1110110
- pointer load, two words: [15:8] = 8'hEE
- memory move, two words: [15:12] = 4'hC
- long branch: [15:11] = 5'b11010, signed offset in [10:0]
- conditional branch: [15:11] = 5'b11100, signed offset in [7:0]
- skip: [15:9] = 7'b0110011
- filler: [15:12] = 4'hF
- everything else: plain single-word instruction

Top module: `fsq_fetch_seq`

## Requirements
- R1: During reset and in the first cycle after it, imem_addr is 0 and ex_valid is 0. The first operation issued after reset has ex_pc 0.
- R2: With no redirect, imem_addr advances by one word per cycle, so the byte counter advances by 2. Consecutive single-word issues come on consecutive cycles with ex_pc rising by 2, and ex_pc[0] is always 0.
- R3: A word from a two-word group is not issued by itself. The following word is consumed as its companion, and one operation is issued two cycles after the previous issue. That operation has ex_two=1, ex_word set to the first word, ex_lit set to the companion's bits [11:0], and ex_pc set to the first word's address. Single-word issues have ex_two=0 and ex_lit=0.
- R4: A word with top nibble 4'hF in first-word position is issued with ex_nop=1. It causes no redirect, and the next word issues on the next cycle.
- R5: When a skip word is decoded with skip_cond=1, the next word is issued with ex_nop=1 and no other effect. If that word opens a two-word group, its companion is then issued separately as a filler no-operation. With skip_cond=0 the next word executes normally.
- R6: An absolute jump or call redirects fetch to byte address {companion[11:0], first[7:0], 1'b0}, which is the 20-bit word address shifted left by one.
- R7: A long branch always redirects. A conditional branch redirects only when br_taken=1. The target is (address of the branch word) + 2 + 2 × (sign-extended offset). When not taken, fetch continues sequentially.
- R8: On a redirect, the word already in flight is discarded and never issued. Exactly one cycle with ex_valid=0 separates the redirecting issue from the issue of the target word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 20 | Word address to program memory (counter bits [20:1]) |
| imem_rdata | input | 16 | Word returned by program memory, one cycle after the address |
| skip_cond | input | 1 | Skip condition, sampled while a skip word is decoded |
| br_taken | input | 1 | Conditional branch outcome, sampled while the branch is decoded |
| ex_valid | output | 1 | An operation is issued this cycle |
| ex_nop | output | 1 | Issued operation is a no-operation |
| ex_two | output | 1 | Issued operation is a combined two-word operation |
| ex_word | output | 16 | First (or only) instruction word |
| ex_lit | output | 12 | Companion literal for two-word operations, else 0 |
| ex_pc | output | 21 | Byte address of the issued operation's first word |

## Verification
The assertions take it for granted that the word after any two-word opener in program memory carries 4'hF in its top nibble. They also assume that skip_cond and br_taken are meaningful in the cycle the skip or branch word sits on imem_rdata. The stimulus meets both conditions: every program pairs each opener with a well-formed companion, and both condition inputs are held constant for a whole run. As a result, a given program has exactly one legal outcome, which the bench can predict.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [3:0] {
    K_PLAIN, K_FILLER, K_SKIP, K_BRL, K_BRC,
    K_JMP,   K_CALL,   K_MOVE, K_LDPTR
  } kind_t;

  // Opcode classification of a word seen in first-word position.
  function automatic kind_t classify(input logic [15:0] w);
    kind_t k;
    if      (w[15:12] == 4'hF)        k = K_FILLER;
    else if (w[15:8]  == 8'hEF)       k = K_JMP;
    else if (w[15:9]  == 7'b1110110)  k = K_CALL;
    else if (w[15:8]  == 8'hEE)       k = K_LDPTR;
    else if (w[15:11] == 5'b11100)    k = K_BRC;
    else if (w[15:11] == 5'b11010)    k = K_BRL;
    else if (w[15:12] == 4'hC)        k = K_MOVE;
    else if (w[15:9]  == 7'b0110011)  k = K_SKIP;
    else                              k = K_PLAIN;
    return k;
  endfunction

  function automatic logic is_pair(input kind_t k);
    return (k == K_JMP) || (k == K_CALL) || (k == K_MOVE) || (k == K_LDPTR);
  endfunction

  function automatic logic is_abs(input kind_t k);
    return (k == K_JMP) || (k == K_CALL);
  endfunction

endpackage

// File: rtl/fsq_decode.sv
module fsq_decode
  import fsq_pkg::*;
#(
  parameter int IW    = 16,
  parameter int OFF_W = 11
) (
  input  logic [IW-1:0]           word,
  output kind_t                   kind,
  output logic                    pair,
  output logic                    abs_jump,
  output logic signed [OFF_W-1:0] off
);

  localparam int SHORT_W = 8;

  always_comb begin
    kind     = classify(word);
    pair     = is_pair(kind);
    abs_jump = is_abs(kind);
    if (kind == K_BRC)
      off = OFF_W'(signed'(word[SHORT_W-1:0]));
    else
      off = signed'(word[OFF_W-1:0]);
  end

endmodule

// File: rtl/fsq_pc.sv
module fsq_pc #(
  parameter int PC_W  = 21,
  parameter int LIT_W = 12,
  parameter int OFF_W = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take_abs,
  input  logic                    take_rel,
  input  logic [LIT_W-1:0]        abs_hi,
  input  logic [7:0]              abs_lo,
  input  logic [PC_W-1:0]         rel_base,
  input  logic signed [OFF_W-1:0] rel_off,
  output logic [PC_W-1:0]         pc_q
);

  localparam int WA_W = PC_W - 1;

  // Absolute target: word address split across both words, scaled to bytes.
  function automatic logic [PC_W-1:0] abs_target(input logic [LIT_W-1:0] hi,
                                                  input logic [7:0] lo);
    logic [WA_W-1:0] wa;
    wa = WA_W'({hi, lo});
    return {wa, 1'b0};
  endfunction

  // Relative target: next instruction address plus twice the word offset.
  function automatic logic [PC_W-1:0] rel_target(input logic [PC_W-1:0] base,
                                                  input logic signed [OFF_W-1:0] o);
    logic [PC_W-1:0] ext;
    ext = PC_W'(o);
    return base + PC_W'(2) + {ext[PC_W-2:0], 1'b0};
  endfunction

  logic [PC_W-1:0] tgt;

  always_comb begin
    if (take_abs) tgt = abs_target(abs_hi, abs_lo);
    else          tgt = rel_target(rel_base, rel_off);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   pc_q <= '0;
    else if (take_abs || take_rel) pc_q <= tgt;
    else                          pc_q <= pc_q + PC_W'(2);
  end

endmodule

// File: rtl/fsq_fetch_seq.sv
module fsq_fetch_seq
  import fsq_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int IW    = 16,
  parameter int LIT_W = 12,
  parameter int OFF_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-2:0]   imem_addr,
  input  logic [IW-1:0]     imem_rdata,
  input  logic              skip_cond,
  input  logic              br_taken,
  output logic              ex_valid,
  output logic              ex_nop,
  output logic              ex_two,
  output logic [IW-1:0]     ex_word,
  output logic [LIT_W-1:0]  ex_lit,
  output logic [PC_W-1:0]   ex_pc
);

  logic [PC_W-1:0]         pc_q;
  logic [PC_W-1:0]         fetch_pc;
  logic                    fetch_vld;
  logic                    ext_pending;
  logic                    kill_next;
  logic [IW-1:0]           hold_word;
  logic [PC_W-1:0]         hold_pc;
  logic                    hold_abs;

  kind_t                   kind;
  logic                    pair;
  logic                    abs_jump;
  logic signed [OFF_W-1:0] off;

  // Named events for the checker.
  logic live, start_pair, take_skip, take_rel, take_abs, redirect;

  fsq_decode #(.IW(IW), .OFF_W(OFF_W)) u_dec (
    .word     (imem_rdata),
    .kind     (kind),
    .pair     (pair),
    .abs_jump (abs_jump),
    .off      (off)
  );

  always_comb begin
    live       = fetch_vld && !ext_pending && !kill_next;
    start_pair = live && pair;
    take_skip  = live && (kind == K_SKIP) && skip_cond;
    take_rel   = live && ((kind == K_BRL) || ((kind == K_BRC) && br_taken));
    take_abs   = fetch_vld && ext_pending && hold_abs;
    redirect   = take_rel || take_abs;
  end

  fsq_pc #(.PC_W(PC_W), .LIT_W(LIT_W), .OFF_W(OFF_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_abs (take_abs),
    .take_rel (take_rel),
    .abs_hi   (imem_rdata[LIT_W-1:0]),
    .abs_lo   (hold_word[7:0]),
    .rel_base (fetch_pc),
    .rel_off  (off),
    .pc_q     (pc_q)
  );

  assign imem_addr = pc_q[PC_W-1:1];

  // Fetch tracking and sequencing state.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_vld   <= 1'b0;
      fetch_pc    <= '0;
      ext_pending <= 1'b0;
      kill_next   <= 1'b0;
      hold_word   <= '0;
      hold_pc     <= '0;
      hold_abs    <= 1'b0;
    end else begin
      fetch_vld   <= !redirect;
      fetch_pc    <= pc_q;
      ext_pending <= start_pair;
      kill_next   <= take_skip;
      if (start_pair) begin
        hold_word <= imem_rdata;
        hold_pc   <= fetch_pc;
        hold_abs  <= abs_jump;
      end
    end
  end

  // Registered issue port.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_valid <= 1'b0;
      ex_nop   <= 1'b0;
      ex_two   <= 1'b0;
      ex_word  <= '0;
      ex_lit   <= '0;
      ex_pc    <= '0;
    end else if (fetch_vld && ext_pending) begin
      ex_valid <= 1'b1;
      ex_nop   <= 1'b0;
      ex_two   <= 1'b1;
      ex_word  <= hold_word;
      ex_lit   <= imem_rdata[LIT_W-1:0];
      ex_pc    <= hold_pc;
    end else if (fetch_vld && !start_pair) begin
      ex_valid <= 1'b1;
      ex_nop   <= kill_next || (kind == K_FILLER);
      ex_two   <= 1'b0;
      ex_word  <= imem_rdata;
      ex_lit   <= '0;
      ex_pc    <= fetch_pc;
    end else begin
      ex_valid <= 1'b0;
      ex_nop   <= 1'b0;
      ex_two   <= 1'b0;
      ex_word  <= '0;
      ex_lit   <= '0;
      ex_pc    <= '0;
    end
  end

endmodule

// File: rtl/fsq_chk.sv
module fsq_chk #(
  parameter int PC_W = 21,
  parameter int IW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            redirect,
  input logic            fetch_vld,
  input logic            ext_pending,
  input logic            kill_next,
  input logic [PC_W-2:0] imem_addr,
  input logic [IW-1:0]   imem_rdata,
  input logic            ex_valid,
  input logic            ex_nop,
  input logic            ex_two,
  input logic [PC_W-1:0] ex_pc
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!ex_valid && imem_addr == '0)); // R1
  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n) ex_valid |-> !ex_pc[0]); // R2
  AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n) !redirect |=> (imem_addr == (PC_W-1)'($past(imem_addr) + 1'b1))); // R2
  AST_EXT_WORD: assert property (@(posedge clk) disable iff (!rst_n) ext_pending |-> (fetch_vld && imem_rdata[IW-1:IW-4] == 4'hF)); // R3
  AST_EXT_ONE: assert property (@(posedge clk) disable iff (!rst_n) ext_pending |=> !ext_pending); // R3
  AST_PAIR_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) ext_pending |=> (ex_valid && ex_two)); // R3
  AST_FILLER_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (fetch_vld && !ext_pending && imem_rdata[IW-1:IW-4] == 4'hF) |-> !redirect); // R4
  AST_KILL_NOP: assert property (@(posedge clk) disable iff (!rst_n) (kill_next && fetch_vld) |=> (ex_valid && ex_nop)); // R5
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) redirect |=> !fetch_vld); // R8
  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n) redirect |=> ##1 !ex_valid); // R8

endmodule

bind fsq_fetch_seq fsq_chk #(.PC_W(PC_W), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .redirect    (redirect),
  .fetch_vld   (fetch_vld),
  .ext_pending (ext_pending),
  .kill_next   (kill_next),
  .imem_addr   (imem_addr),
  .imem_rdata  (imem_rdata),
  .ex_valid    (ex_valid),
  .ex_nop      (ex_nop),
  .ex_two      (ex_two),
  .ex_pc       (ex_pc)
);

// File: tb/sim_fsq_fetch_seq.sv
module sim_fsq_fetch_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] imem_addr;
  logic [15:0] imem_rdata;
  logic        skip_cond = 1'b0;
  logic        br_taken = 1'b0;
  logic        ex_valid, ex_nop, ex_two;
  logic [15:0] ex_word;
  logic [11:0] ex_lit;
  logic [20:0] ex_pc;

  always #4 clk = ~clk;

  fsq_fetch_seq u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .skip_cond(skip_cond), .br_taken(br_taken), .ex_valid(ex_valid), .ex_nop(ex_nop),
    .ex_two(ex_two), .ex_word(ex_word), .ex_lit(ex_lit), .ex_pc(ex_pc)
  );

  logic [15:0] mem [0:1023];
  always @(posedge clk) imem_rdata <= mem[imem_addr[9:0]];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_log = 0;
  int base = 0;
  bit arm = 1'b0;
  logic [15:0] lg_w [0:255];
  logic [11:0] lg_l [0:255];
  logic        lg_t [0:255];
  logic        lg_n [0:255];
  logic [20:0] lg_p [0:255];
  int          lg_c [0:255];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (arm && ex_valid && (n_log - base) < 16 && n_log < 256) begin
      lg_w[n_log] <= ex_word;
      lg_l[n_log] <= ex_lit;
      lg_t[n_log] <= ex_two;
      lg_n[n_log] <= ex_nop;
      lg_p[n_log] <= ex_pc;
      lg_c[n_log] <= cyc;
      n_log <= n_log + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
  endtask

  task automatic run_prog(input logic sk, input logic bt);
    arm = 1'b0;
    rst_n = 1'b0;
    skip_cond = sk;
    br_taken = bt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr == 20'd0 && !ex_valid, "R1", "in reset", {imem_addr, ex_valid}, 64'd0);
    rst_n = 1'b1;
    @(posedge clk);
    base = n_log;
    arm = 1'b1;
    @(negedge clk);
    chk(!ex_valid, "R1", "first cycle after reset", {63'd0, ex_valid}, 64'd0);
    repeat (40) @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic exp_op(input int k, input logic [15:0] w, input logic [11:0] lit,
                        input logic two, input logic nop, input logic [20:0] pc,
                        input string req);
    logic [63:0] a, e;
    int i;
    i = base + k;
    e = {13'd0, w, lit, two, nop, pc};
    if (k >= n_log - base) a = '1;
    else a = {13'd0, lg_w[i], lg_l[i], lg_t[i], lg_n[i], lg_p[i]};
    chk(a == e, req, $sformatf("issue %0d {word,lit,two,nop,pc}", k), a, e);
  endtask

  task automatic exp_gap(input int k, input int g, input string req);
    int a;
    if (k >= n_log - base || k < 1) a = -1;
    else a = lg_c[base + k] - lg_c[base + k - 1];
    chk(a == g, req, $sformatf("cycles between issue %0d and %0d", k - 1, k), 64'(a), 64'(g));
  endtask

  // R1, R2: sequential fetch from reset
  task automatic t_sequential();
    clear_mem();
    mem[0] = 16'h1234; mem[1] = 16'h2345; mem[2] = 16'h3456; mem[3] = 16'h0101;
    run_prog(1'b0, 1'b0);
    exp_op(0, 16'h1234, 12'h0, 1'b0, 1'b0, 21'h0, "R1");
    exp_op(1, 16'h2345, 12'h0, 1'b0, 1'b0, 21'h2, "R2");
    exp_op(2, 16'h3456, 12'h0, 1'b0, 1'b0, 21'h4, "R2");
    exp_op(3, 16'h0101, 12'h0, 1'b0, 1'b0, 21'h6, "R2");
    exp_gap(1, 1, "R2");
    exp_gap(3, 1, "R2");
  endtask

  // R3: two-word groups issue once with their literal
  task automatic t_pairs();
    clear_mem();
    mem[0] = 16'h0101; mem[1] = 16'hC123; mem[2] = 16'hF456;
    mem[3] = 16'hEE12; mem[4] = 16'hF0AB; mem[5] = 16'h0202;
    run_prog(1'b0, 1'b0);
    exp_op(0, 16'h0101, 12'h000, 1'b0, 1'b0, 21'h0, "R3");
    exp_op(1, 16'hC123, 12'h456, 1'b1, 1'b0, 21'h2, "R3");
    exp_op(2, 16'hEE12, 12'h0AB, 1'b1, 1'b0, 21'h6, "R3");
    exp_op(3, 16'h0202, 12'h000, 1'b0, 1'b0, 21'hA, "R3");
    exp_gap(1, 2, "R3");
    exp_gap(2, 2, "R3");
    exp_gap(3, 1, "R3");
  endtask

  // R4: filler word in first position
  task automatic t_filler();
    clear_mem();
    mem[0] = 16'hF777; mem[1] = 16'h0303;
    run_prog(1'b0, 1'b1);
    exp_op(0, 16'hF777, 12'h0, 1'b0, 1'b1, 21'h0, "R4");
    exp_op(1, 16'h0303, 12'h0, 1'b0, 1'b0, 21'h2, "R4");
    exp_gap(1, 1, "R4");
  endtask

  // R5: skip over the opener of a pair, then over a single word; and not taken
  task automatic t_skip();
    clear_mem();
    mem[0] = 16'h6655; mem[1] = 16'hC123; mem[2] = 16'hF456; mem[3] = 16'h2400;
    run_prog(1'b1, 1'b0);
    exp_op(0, 16'h6655, 12'h0, 1'b0, 1'b0, 21'h0, "R5");
    exp_op(1, 16'hC123, 12'h0, 1'b0, 1'b1, 21'h2, "R5");
    exp_op(2, 16'hF456, 12'h0, 1'b0, 1'b1, 21'h4, "R5");
    exp_op(3, 16'h2400, 12'h0, 1'b0, 1'b0, 21'h6, "R5");
    run_prog(1'b0, 1'b0);
    exp_op(0, 16'h6655, 12'h000, 1'b0, 1'b0, 21'h0, "R5");
    exp_op(1, 16'hC123, 12'h456, 1'b1, 1'b0, 21'h2, "R5");
    exp_op(2, 16'h2400, 12'h000, 1'b0, 1'b0, 21'h6, "R5");
    clear_mem();
    mem[0] = 16'h6600; mem[1] = 16'h1111; mem[2] = 16'h2222;
    run_prog(1'b1, 1'b0);
    exp_op(1, 16'h1111, 12'h0, 1'b0, 1'b1, 21'h2, "R5");
    exp_op(2, 16'h2222, 12'h0, 1'b0, 1'b0, 21'h4, "R5");
  endtask

  // R6, R8: absolute jump and call
  task automatic t_absolute();
    clear_mem();
    mem[0] = 16'h0101; mem[1] = 16'hEF10; mem[2] = 16'hF002; mem[3] = 16'h0909;
    mem[10'h210] = 16'h5555; mem[10'h211] = 16'h5656;
    run_prog(1'b0, 1'b0);
    exp_op(1, 16'hEF10, 12'h002, 1'b1, 1'b0, 21'h2, "R6");
    exp_op(2, 16'h5555, 12'h000, 1'b0, 1'b0, 21'h420, "R6");
    exp_op(3, 16'h5656, 12'h000, 1'b0, 1'b0, 21'h422, "R6");
    exp_gap(2, 2, "R8");
    clear_mem();
    mem[0] = 16'hEF03; mem[1] = 16'hF000; mem[2] = 16'h0BAD; mem[3] = 16'h4444;
    run_prog(1'b0, 1'b0);
    exp_op(0, 16'hEF03, 12'h000, 1'b1, 1'b0, 21'h0, "R6");
    exp_op(1, 16'h4444, 12'h000, 1'b0, 1'b0, 21'h6, "R6");
    clear_mem();
    mem[0] = 16'hEC05; mem[1] = 16'hF000;
    mem[2] = 16'h0777; mem[3] = 16'h0777; mem[4] = 16'h0777; mem[5] = 16'h5151;
    run_prog(1'b0, 1'b0);
    exp_op(0, 16'hEC05, 12'h000, 1'b1, 1'b0, 21'h0, "R6");
    exp_op(1, 16'h5151, 12'h000, 1'b0, 1'b0, 21'hA, "R6");
    exp_gap(1, 2, "R8");
  endtask

  // R7, R8: long branches forward and backward
  task automatic t_long_branch();
    clear_mem();
    mem[0] = 16'hD009; mem[1] = 16'h0777;
    mem[10] = 16'hD7FB; mem[11] = 16'h0777;
    mem[6] = 16'h6161; mem[7] = 16'h7171;
    run_prog(1'b0, 1'b0);
    exp_op(0, 16'hD009, 12'h0, 1'b0, 1'b0, 21'd0, "R7");
    exp_op(1, 16'hD7FB, 12'h0, 1'b0, 1'b0, 21'd20, "R7");
    exp_op(2, 16'h6161, 12'h0, 1'b0, 1'b0, 21'd12, "R7");
    exp_op(3, 16'h7171, 12'h0, 1'b0, 1'b0, 21'd14, "R7");
    exp_gap(1, 2, "R8");
    exp_gap(2, 2, "R8");
    exp_gap(3, 1, "R8");
  endtask

  // R7: conditional branch taken and not taken
  task automatic t_cond_branch();
    clear_mem();
    mem[0] = 16'hE008; mem[1] = 16'h1717; mem[9] = 16'hE0FB; mem[5] = 16'h5252;
    run_prog(1'b0, 1'b1);
    exp_op(0, 16'hE008, 12'h0, 1'b0, 1'b0, 21'd0, "R7");
    exp_op(1, 16'hE0FB, 12'h0, 1'b0, 1'b0, 21'd18, "R7");
    exp_op(2, 16'h5252, 12'h0, 1'b0, 1'b0, 21'd10, "R7");
    exp_gap(2, 2, "R8");
    run_prog(1'b0, 1'b0);
    exp_op(0, 16'hE008, 12'h0, 1'b0, 1'b0, 21'd0, "R7");
    exp_op(1, 16'h1717, 12'h0, 1'b0, 1'b0, 21'd2, "R7");
    exp_gap(1, 1, "R7");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected at most 20000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    t_sequential();
    t_pairs();
    t_filler();
    t_skip();
    t_absolute();
    t_long_branch();
    t_cond_branch();
    finish_run();
  end

endmodule